// File: doc/BRIEF.md
# Video Pixel Bus Formatter

This block takes one video sample at a time, either a 12-bit luma value with two 12-bit chroma values or three 8-bit red/green/blue values, and places it on a 24-bit parallel pixel bus. An 8-bit format code picks the layout. The layouts are single-data-rate 4:2:2 in 8, 12, 16 and 24 bits, single-data-rate 4:4:4 RGB, and three double-data-rate layouts that carry two words in each output clock period. Beside the data it drives a per-bit enable vector, so that a pad ring can float unused pins, a pixel clock, and an error flag for format codes it does not know.

The block runs on one core clock. The pixel clock is a register that inverts on every core edge, so one output period is two core cycles. The edge that raises the pixel clock is the capture edge: inputs are sampled there, the format code takes effect there, and the rising-phase word is launched. The edge that lowers the pixel clock launches the falling-phase word. Only the 24-bit DDR RGB layout samples the inputs a second time on that edge.

Top module: `vid_bus_formatter`

## Requirements
- R1: While reset is held, and until the first capture edge after it, bus_data, bus_oe and fmt_err are all zero and pix_clk is low.
- R2: pix_clk inverts on every core clock edge. bus_oe and fmt_err change only on capture edges, which are the edges that take pix_clk from low to high.
- R3: Codes 0x00 and 0x0A send a pixel over two output periods, chroma first and then luma. Code 0x00 places sample bits [11:4] on bus [15:8] and enables only those 8 bits (0x00FF00). Code 0x0A also places sample bits [3:0] on bus [23:20] and enables 0xF0FF00.
- R4: Code 0x80 drives luma [11:4] on bus [15:8] and chroma [11:4] on bus [7:0], with enable 0x00FFFF. Code 0x8A drives luma [11:4] on [15:8], luma [3:0] on [23:20], chroma [11:4] on [7:0] and chroma [3:0] on [19:16], with all 24 bits enabled.
- R5: Code 0x40 drives red on [23:16], green on [15:8] and blue on [7:0], held for the whole output period, with all bits enabled.
- R6: Codes 0x20 and 0x2A use the 0x00 and 0x0A bit placement and enables. They drive chroma while pix_clk is high and the luma of the same pixel while pix_clk is low.
- R7: Code 0x60 drives the RGB word sampled at the capture edge while pix_clk is high, and the RGB word sampled at the following falling edge while pix_clk is low. All bits are enabled.
- R8: Any other code sets fmt_err and drives bus_oe and bus_data to all zeros. The flag clears at the first capture edge that sees a known code.
- R9: Every bus_data bit whose bus_oe bit is 0 reads 0.
- R10: A pixel slot sampled with pix_vld low drives IDLE_WORD masked by the enables (zero by default) and makes the next valid 4:2:2 pixel carry Cb. In code 0x60 the same applies to a falling-phase sample.
- R11: In the 4:2:2 codes, chroma alternates Cb, Cr, Cb, ... on successive valid pixels.
- R12: Input values present at edges that take no sample are ignored: the falling edge in the SDR and 4:2:2 DDR codes, and the luma period of codes 0x00 and 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the output clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 8 | Bus layout code |
| pix_vld | input | 1 | Sample inputs carry a pixel |
| y_in | input | 12 | Luma sample |
| cb_in | input | 12 | Blue-difference chroma sample |
| cr_in | input | 12 | Red-difference chroma sample |
| r_in | input | 8 | Red sample |
| g_in | input | 8 | Green sample |
| b_in | input | 8 | Blue sample |
| pix_clk | output | 1 | Output pixel clock |
| bus_data | output | 24 | Pixel bus data |
| bus_oe | output | 24 | Per-bit drive enable; 0 means the pin floats |
| fmt_err | output | 1 | Unknown layout code in use |

## Verification
The bench uses the default IDLE_WORD of zero. As a result, every blank slot and every disabled bit must read exactly zero, so a leak of stale data into an idle slot or onto a floating pin shows up as a plain mismatch. One pixel pair drives all nine codes. The rising-phase word, the falling-phase word and the next period's word are each compared, which reaches the Cb/Cr turn, the luma hold in the serial codes and the odd-pixel capture in DDR RGB. Directed runs then cover restarting the chroma order after a gap, inputs that change during an ignored luma period, and a blank falling-phase sample in DDR RGB.

// File: rtl/vid_bus_formatter.sv
module vid_bus_formatter #(
  parameter logic [23:0] IDLE_WORD = 24'h000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  fmt_sel,
  input  logic        pix_vld,
  input  logic [11:0] y_in,
  input  logic [11:0] cb_in,
  input  logic [11:0] cr_in,
  input  logic [7:0]  r_in,
  input  logic [7:0]  g_in,
  input  logic [7:0]  b_in,
  output logic        pix_clk,
  output logic [23:0] bus_data,
  output logic [23:0] bus_oe,
  output logic        fmt_err
);

  typedef enum logic [3:0] {
    F_BAD, F_S8, F_S12, F_S16, F_S24, F_RGB, F_D8, F_D12, F_DRGB
  } fmt_t;

  fmt_t        mode, mode_q;
  logic [23:0] mask, rise_w, luma_w, chroma_w, rgb_w;
  logic [23:0] y_hold;
  logic [11:0] chroma;
  logic        ph, step, cr_turn, serial, is422;

  function automatic logic [23:0] narrow(input logic [11:0] v);
    return {8'h00, v[11:4], 8'h00};
  endfunction

  function automatic logic [23:0] split(input logic [11:0] v);
    return {v[3:0], 4'h0, v[11:4], 8'h00};
  endfunction

  always_comb begin
    case (fmt_sel)
      8'h00:   mode = F_S8;
      8'h0A:   mode = F_S12;
      8'h80:   mode = F_S16;
      8'h8A:   mode = F_S24;
      8'h40:   mode = F_RGB;
      8'h20:   mode = F_D8;
      8'h2A:   mode = F_D12;
      8'h60:   mode = F_DRGB;
      default: mode = F_BAD;
    endcase
  end

  always_comb begin
    case (mode)
      F_S8, F_D8:   mask = 24'h00FF00;
      F_S12, F_D12: mask = 24'hF0FF00;
      F_S16:        mask = 24'h00FFFF;
      F_BAD:        mask = 24'h000000;
      default:      mask = 24'hFFFFFF;
    endcase
  end

  assign serial = (mode == F_S8) || (mode == F_S12);
  assign is422  = (mode != F_RGB) && (mode != F_DRGB) && (mode != F_BAD);
  assign chroma = cr_turn ? cr_in : cb_in;
  assign rgb_w  = {r_in, g_in, b_in};

  always_comb begin
    case (mode)
      F_S12, F_D12: begin
        luma_w   = split(y_in);
        chroma_w = split(chroma);
      end
      default: begin
        luma_w   = narrow(y_in);
        chroma_w = narrow(chroma);
      end
    endcase
  end

  always_comb begin
    case (mode)
      F_S8, F_S12, F_D8, F_D12: rise_w = chroma_w;
      F_S16:                    rise_w = {8'h00, y_in[11:4], chroma[11:4]};
      F_S24:                    rise_w = {y_in[3:0], chroma[3:0], y_in[11:4], chroma[11:4]};
      F_RGB, F_DRGB:            rise_w = rgb_w;
      default:                  rise_w = 24'h000000;
    endcase
  end

  assign pix_clk = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= 1'b0;
      step     <= 1'b0;
      cr_turn  <= 1'b0;
      y_hold   <= 24'h000000;
      mode_q   <= F_BAD;
      bus_data <= 24'h000000;
      bus_oe   <= 24'h000000;
      fmt_err  <= 1'b0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        mode_q  <= mode;
        bus_oe  <= mask;
        fmt_err <= (mode == F_BAD);
        if (serial && step) begin
          bus_data <= y_hold & mask;
          step     <= 1'b0;
        end else if (pix_vld) begin
          bus_data <= rise_w & mask;
          y_hold   <= luma_w;
          step     <= serial;
          if (is422) cr_turn <= ~cr_turn;
        end else begin
          bus_data <= IDLE_WORD & mask;
          y_hold   <= IDLE_WORD;
          step     <= 1'b0;
          cr_turn  <= 1'b0;
        end
      end else begin
        if (mode_q == F_D8 || mode_q == F_D12)
          bus_data <= y_hold & bus_oe;
        else if (mode_q == F_DRGB)
          bus_data <= (pix_vld ? rgb_w : IDLE_WORD) & bus_oe;
      end
    end
  end

endmodule

// File: rtl/vid_bus_formatter_chk.sv
module vid_bus_formatter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_clk,
  input logic [23:0] bus_data,
  input logic [23:0] bus_oe,
  input logic        fmt_err
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  a_r2_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> pix_clk != $past(pix_clk));

  a_r2_oe_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pix_clk) |=> ($stable(bus_oe) && $stable(fmt_err)));

  a_r8_bad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> (bus_oe == 24'h000000 && bus_data == 24'h000000));

  a_r9_off_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data & ~bus_oe) == 24'h000000);

  a_r1_quiet_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (bus_oe == 24'h000000 && !fmt_err && !pix_clk));

endmodule

bind vid_bus_formatter vid_bus_formatter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk),
  .bus_data(bus_data), .bus_oe(bus_oe), .fmt_err(fmt_err)
);

// File: tb/vid_bus_formatter_bench.sv
module vid_bus_formatter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  fmt_sel = 8'h00;
  logic        pix_vld = 1'b0;
  logic [11:0] y_in = '0, cb_in = '0, cr_in = '0;
  logic [7:0]  r_in = '0, g_in = '0, b_in = '0;
  logic        pix_clk, fmt_err;
  logic [23:0] bus_data, bus_oe;

  always #5 clk = ~clk;

  vid_bus_formatter u_vid_bus_formatter (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .pix_vld(pix_vld),
    .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .r_in(r_in), .g_in(g_in), .b_in(b_in),
    .pix_clk(pix_clk), .bus_data(bus_data), .bus_oe(bus_oe), .fmt_err(fmt_err)
  );

  typedef struct packed {
    logic [7:0]  fmt;
    logic [23:0] oe;
    logic [23:0] w_a;
    logic [23:0] w_b;
    logic [23:0] w_c;
    logic        err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 24'h00FF00, 24'h001200, 24'h001200, 24'h00AB00, 1'b0},
    '{8'h0A, 24'hF0FF00, 24'h301200, 24'h301200, 24'hC0AB00, 1'b0},
    '{8'h80, 24'h00FFFF, 24'h00AB12, 24'h00AB12, 24'h00AB45, 1'b0},
    '{8'h8A, 24'hFFFFFF, 24'hC3AB12, 24'hC3AB12, 24'hC6AB45, 1'b0},
    '{8'h40, 24'hFFFFFF, 24'h112233, 24'h112233, 24'h112233, 1'b0},
    '{8'h33, 24'h000000, 24'h000000, 24'h000000, 24'h000000, 1'b1},
    '{8'h20, 24'h00FF00, 24'h001200, 24'h00AB00, 24'h004500, 1'b0},
    '{8'h2A, 24'hF0FF00, 24'h301200, 24'hC0AB00, 24'h604500, 1'b0},
    '{8'h60, 24'hFFFFFF, 24'h112233, 24'hC4D5E6, 24'h112233, 1'b0}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(input int set, input logic v);
    pix_vld = v;
    case (set)
      0: begin y_in = 12'hABC; cb_in = 12'h123; cr_in = 12'h456;
               r_in = 8'h11; g_in = 8'h22; b_in = 8'h33; end
      1: begin y_in = 12'h987; cb_in = 12'h654; cr_in = 12'h321;
               r_in = 8'hC4; g_in = 8'hD5; b_in = 8'hE6; end
      default: begin y_in = 12'h5F0; cb_in = 12'h999; cr_in = 12'h7E1;
               r_in = 8'h77; g_in = 8'h88; b_in = 8'h99; end
    endcase
  endtask

  // leaves the bench at a negedge with pix_clk low after one blank slot
  task automatic idle_align(input logic [7:0] f);
    fmt_sel = f;
    load(0, 1'b0);
    @(negedge clk);
    while (pix_clk !== 1'b0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rise_chk(input string req, input logic [23:0] exp);
    @(negedge clk);
    chk(req, bus_data, exp);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    load(0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 data", bus_data, 24'h0);
    chk("R1 oe", bus_oe, 24'h0);
    chk("R1 err", {23'h0, fmt_err}, 24'h0);
    chk("R1 clk", {23'h0, pix_clk}, 24'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      case (VECS[i].fmt)
        8'h00, 8'h0A: tag = "R3";
        8'h80, 8'h8A: tag = "R4";
        8'h40:        tag = "R5";
        8'h20, 8'h2A: tag = "R6";
        8'h60:        tag = "R7";
        default:      tag = "R8";
      endcase
      idle_align(VECS[i].fmt);
      load(0, 1'b1);
      @(negedge clk);
      chk({tag, " rise word"}, bus_data, VECS[i].w_a);
      chk("R9 enables", bus_oe, VECS[i].oe);
      chk("R8 error flag", {23'h0, fmt_err}, {23'h0, VECS[i].err});
      chk("R2 clk high", {23'h0, pix_clk}, 24'h1);
      load(1, 1'b1);
      @(negedge clk);
      chk((VECS[i].fmt == 8'h60 || VECS[i].fmt == 8'h20 || VECS[i].fmt == 8'h2A)
          ? {tag, " fall word"} : "R12 fall ignored", bus_data, VECS[i].w_b);
      chk("R2 clk low", {23'h0, pix_clk}, 24'h0);
      load(0, 1'b1);
      @(negedge clk);
      chk({tag, " next period"}, bus_data, VECS[i].w_c);
      @(negedge clk);
      load(0, 1'b0);
    end

    // R11 / R10: chroma order and restart after a blank slot
    idle_align(8'h80);
    load(0, 1'b1);
    rise_chk("R11 Cb", 24'h00AB12);
    rise_chk("R11 Cr", 24'h00AB45);
    rise_chk("R11 Cb again", 24'h00AB12);
    load(0, 1'b0);
    @(negedge clk);
    chk("R10 blank word", bus_data, 24'h000000);
    chk("R10 enables kept", bus_oe, 24'h00FFFF);
    @(negedge clk);
    load(0, 1'b1);
    rise_chk("R10 restart Cb", 24'h00AB12);

    // R3 / R12: byte-serial over two pixels, inputs changed during luma period
    idle_align(8'h00);
    load(0, 1'b1);
    rise_chk("R3 Cb0", 24'h001200);
    load(2, 1'b1);
    rise_chk("R12 luma held", 24'h00AB00);
    rise_chk("R11 Cr1", 24'h007E00);
    rise_chk("R3 Y1", 24'h005F00);

    // R10 in DDR RGB: blank falling-phase sample
    idle_align(8'h60);
    load(0, 1'b1);
    @(negedge clk);
    chk("R7 even pixel", bus_data, 24'h112233);
    load(1, 1'b0);
    @(negedge clk);
    chk("R10 blank odd pixel", bus_data, 24'h000000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule